// File: doc/BRIEF.md
# Cipher Bit/Byte Permutation Execution Unit

This unit executes three cipher-oriented operations on values that a register file has already read out. A scatter operation moves eight chosen bits from the low half-word of a source word into chosen positions of the destination word. A byte shuffle rebuilds a word from any selection of the source's four bytes. A masked parity reduces the source bits picked by a mask to one carry-flag bit. Two 32-bit pattern operands hold the packed indices or the mask. Decoding, register reads and the flag register are outside the block.

Each issued operation is computed combinationally and captured in one registered output stage. The result, its write enables and the carry flag appear one clock after the issue cycle. A two-state machine tracks whether the output stage currently presents a result. The states are `ST_IDLE` (nothing presented) and `ST_SHOW` (result presented). Transition `T_ISSUE` goes from either state to `ST_SHOW` when `issue` is high at a clock edge. Transition `T_DRAIN` goes from either state to `ST_IDLE` when `issue` is low.

Top module: `perm_exec_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid`, `res_we`, `cf_we`, `cf_out` and `res_data` are all zero.
- R2: An operation issued at a clock edge (`issue` high) presents its results from that edge onward, so `out_valid` is high during exactly the cycle after each issue cycle.
- R3: For the scatter operation (op code 1), for each lane i in 0..7, source bit `src_val[pat_b[4i+3:4i]]` is written to result bit `pat_a[4i+3:4i]`.
- R4: For the scatter operation, result bits named by no lane equal the matching bits of `dst_val`, and result bits 31..16 always equal `dst_val[31:16]`.
- R5: For the scatter operation, when several lanes name the same result bit, the lane with the highest index decides its value.
- R6: For the byte shuffle (op code 2), result byte i (bits 8i+7..8i) equals source byte number `pat_a[2i+1:2i]`.
- R7: The byte shuffle ignores `pat_a[31:8]`, all of `pat_b` and `dst_val`.
- R8: For the masked parity (op code 3), `cf_out` equals the XOR of all bits of `src_val & pat_a`, `cf_we` is high, `res_we` is low, and `res_data` carries `dst_val` unchanged.
- R9: Op codes 1 and 2 raise `res_we` with `cf_we` low. Op code 0 (no operation) raises neither, and it drives `res_data` = `dst_val` and `cf_out` = 0. For op codes 0, 1 and 2, `cf_out` is 0.
- R10: In a cycle after an edge with `issue` low, `out_valid`, `res_we` and `cf_we` are low, and `res_data` and `cf_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation present on the inputs this cycle |
| op | input | 2 | Op code: 0 none, 1 scatter, 2 byte shuffle, 3 masked parity |
| src_val | input | 32 | Source register value |
| dst_val | input | 32 | Current destination register value |
| pat_a | input | 32 | First pattern: scatter destination indices, byte selectors or parity mask |
| pat_b | input | 32 | Second pattern: scatter source indices |
| out_valid | output | 1 | Output stage holds a fresh result |
| res_data | output | 32 | Result word for the destination register |
| res_we | output | 1 | Write the destination register |
| cf_out | output | 1 | New carry flag value |
| cf_we | output | 1 | Write the carry flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 4-bit scatter index fields and 8-bit bytes. This gives eight scatter lanes over a 16-bit span and four 2-bit byte selectors. With these values every lane and every byte selector can be aimed at a chosen bit or byte, including colliding lanes and all-same selectors. Unused pattern bits can be filled with ones to show that they are ignored, and the fixed upper half of the scatter result becomes observable.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_BITP = 2'd1,
        OP_BYTP = 2'd2,
        OP_RXOR = 2'd3
    } perm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } stage_state_e;

endpackage

// File: rtl/bit_scatter.sv
module bit_scatter #(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 4,
    localparam int LANES  = WORD_W / FIELD_W,
    localparam int SPAN   = 1 << FIELD_W
) (
    input  logic [SPAN-1:0]   src_low,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] dst_idx,
    input  logic [WORD_W-1:0] src_idx,
    output logic [WORD_W-1:0] scattered
);
    // Ascending lane order: a later lane overrides an earlier one.
    always_comb begin
        scattered = base;
        for (int lane = 0; lane < LANES; lane++) begin
            scattered[dst_idx[lane*FIELD_W +: FIELD_W]] =
                src_low[src_idx[lane*FIELD_W +: FIELD_W]];
        end
    end
endmodule

// File: rtl/byte_shuffle.sv
module byte_shuffle #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int SEL_W  = $clog2(NBYTES),
    localparam int SELS_W = NBYTES * SEL_W
) (
    input  logic [WORD_W-1:0] src,
    input  logic [SELS_W-1:0] sel,
    output logic [WORD_W-1:0] shuffled
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [SEL_W-1:0] pick;
        assign pick = sel[b*SEL_W +: SEL_W];
        assign shuffled[b*BYTE_W +: BYTE_W] = src[pick*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/masked_parity.sv
module masked_parity #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] mask,
    output logic              parity
);
    assign parity = ^(src & mask);
endmodule

// File: rtl/perm_exec_unit.sv
module perm_exec_unit
    import perm_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 4,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] src_val,
    input  logic [WORD_W-1:0] dst_val,
    input  logic [WORD_W-1:0] pat_a,
    input  logic [WORD_W-1:0] pat_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_data,
    output logic              res_we,
    output logic              cf_out,
    output logic              cf_we
);
    localparam int SPAN   = 1 << FIELD_W;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int SELS_W = NBYTES * $clog2(NBYTES);

    perm_op_e     op_e;
    stage_state_e state_q, state_d;
    logic [WORD_W-1:0] scat_w, shuf_w, data_d;
    logic parity_w, we_d, cfwe_d, cf_d;

    assign op_e = perm_op_e'(op);

    bit_scatter #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_scatter (
        .src_low  (src_val[SPAN-1:0]),
        .base     (dst_val),
        .dst_idx  (pat_a),
        .src_idx  (pat_b),
        .scattered(scat_w)
    );

    byte_shuffle #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shuffle (
        .src     (src_val),
        .sel     (pat_a[SELS_W-1:0]),
        .shuffled(shuf_w)
    );

    masked_parity #(.WORD_W(WORD_W)) u_parity (
        .src   (src_val),
        .mask  (pat_a),
        .parity(parity_w)
    );

    // Result selection per op code.
    always_comb begin
        data_d = dst_val;
        we_d   = 1'b0;
        cfwe_d = 1'b0;
        cf_d   = 1'b0;
        unique case (op_e)
            OP_NONE: ;
            OP_BITP: begin data_d = scat_w; we_d = 1'b1; end
            OP_BYTP: begin data_d = shuf_w; we_d = 1'b1; end
            OP_RXOR: begin cf_d = parity_w; cfwe_d = 1'b1; end
        endcase
    end

    // Next-state logic: T_ISSUE / T_DRAIN.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = issue ? ST_SHOW : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            res_we   <= 1'b0;
            cf_out   <= 1'b0;
            cf_we    <= 1'b0;
        end else if (issue) begin
            res_data <= data_d;
            res_we   <= we_d;
            cf_out   <= cf_d;
            cf_we    <= cfwe_d;
        end else begin
            res_we   <= 1'b0;
            cf_we    <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    // R2
    valid_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> out_valid);

    // R10
    quiet_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!out_valid && !res_we && !cf_we && $stable(res_data) && $stable(cf_out)));

    // R9
    enable_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || cf_we) |-> out_valid);

    // R8
    parity_flag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 2'd3) |=> (cf_we && !res_we && res_data == $past(dst_val)));

    // R4
    if (SPAN < WORD_W) begin : g_upper_chk
        scatter_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && op == 2'd1) |=> (res_data[WORD_W-1:SPAN] == $past(dst_val[WORD_W-1:SPAN])));
    end
endmodule

// File: tb/tb_perm_exec_unit.sv
`timescale 1ns/1ps
module tb_perm_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] src_val = '0, dst_val = '0, pat_a = '0, pat_b = '0;
    logic        out_valid, res_we, cf_out, cf_we;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    perm_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op),
        .src_val(src_val), .dst_val(dst_val), .pat_a(pat_a), .pat_b(pat_b),
        .out_valid(out_valid), .res_data(res_data), .res_we(res_we),
        .cf_out(cf_out), .cf_we(cf_we)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [1:0]  op;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] pa;
        logic [31:0] pb;
        logic [31:0] exp_data;
        logic        exp_we;
        logic        exp_cfwe;
        logic        exp_cf;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R3 identity lanes 0..7
        '{"R3", 2'd1, 32'h0000_00A5, 32'hFFFF_FFFF, 32'h7654_3210, 32'h7654_3210, 32'hFFFF_FFA5, 1'b1, 1'b0, 1'b0},
        // R3 source bit 13 into bit 5
        '{"R3", 2'd1, 32'h0000_2000, 32'h1234_0000, 32'h5555_5555, 32'hDDDD_DDDD, 32'h1234_0020, 1'b1, 1'b0, 1'b0},
        // R4 reversal into bits 15..8, upper source ignored
        '{"R4", 2'd1, 32'hABCD_0001, 32'h0000_0000, 32'hFEDC_BA98, 32'h0123_4567, 32'h0000_8000, 1'b1, 1'b0, 1'b0},
        // R5 all lanes hit bit 3, lane 7 reads a one
        '{"R5", 2'd1, 32'h0000_0002, 32'h0000_0000, 32'h3333_3333, 32'h1000_0000, 32'h0000_0008, 1'b1, 1'b0, 1'b0},
        // R5 lane 7 reads a zero and clears bit 3
        '{"R5", 2'd1, 32'h0000_0001, 32'h0000_0008, 32'h3333_3333, 32'h1000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
        // R6 byte reversal
        '{"R6", 2'd2, 32'h1122_3344, 32'hDEAD_BEEF, 32'h0000_001B, 32'h0000_0000, 32'h4433_2211, 1'b1, 1'b0, 1'b0},
        // R7 upper selector bits and pat_b ignored
        '{"R7", 2'd2, 32'hA1B2_C3D4, 32'h5A5A_5A5A, 32'hFFFF_FF00, 32'h1234_5678, 32'hD4D4_D4D4, 1'b1, 1'b0, 1'b0},
        // R6 identity selection
        '{"R6", 2'd2, 32'hCAFE_F00D, 32'h0000_0000, 32'h0000_00E4, 32'hFFFF_FFFF, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b0},
        // R8 three masked ones
        '{"R8", 2'd3, 32'hFFFF_FFFF, 32'h5555_AAAA, 32'h0000_0007, 32'h0000_0000, 32'h5555_AAAA, 1'b0, 1'b1, 1'b1},
        // R8 four masked ones
        '{"R8", 2'd3, 32'hF0F0_F0F0, 32'h0000_1111, 32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_1111, 1'b0, 1'b1, 1'b0},
        // R8 single top bit
        '{"R8", 2'd3, 32'h8000_0001, 32'h7777_0000, 32'h8000_0000, 32'h0000_0000, 32'h7777_0000, 1'b0, 1'b1, 1'b1},
        // R9 no operation
        '{"R9", 2'd0, 32'hFFFF_FFFF, 32'h0BAD_F00D, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] a, input logic [31:0] b);
        issue = 1'b1; op = o; src_val = s; dst_val = d; pat_a = a; pat_b = b;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!out_valid && !res_we && !cf_we && !cf_out, "R1", "flags in reset",
              {28'd0, out_valid, res_we, cf_we, cf_out}, 32'd0);
        check(res_data == 32'd0, "R1", "data in reset", res_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && res_data == 32'd0, "R1", "first cycle after reset", res_data, 32'd0);

        // Table walk, back to back
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].src, VECS[i].dst, VECS[i].pa, VECS[i].pb);
            @(negedge clk);
            check(out_valid, string'(VECS[i].tag), "valid", {31'd0, out_valid}, 32'd1);
            check(res_data == VECS[i].exp_data, string'(VECS[i].tag), "data", res_data, VECS[i].exp_data);
            check(res_we == VECS[i].exp_we && cf_we == VECS[i].exp_cfwe, string'(VECS[i].tag), "enables",
                  {30'd0, res_we, cf_we}, {30'd0, VECS[i].exp_we, VECS[i].exp_cfwe});
            check(cf_out == VECS[i].exp_cf, string'(VECS[i].tag), "carry", {31'd0, cf_out}, {31'd0, VECS[i].exp_cf});
        end

        // R10 gap: load a parity result, then stop issuing with new inputs
        drive(2'd3, 32'h0000_0001, 32'h1357_9BDF, 32'h0000_0001, 32'h0);
        @(negedge clk);
        held = res_data;
        issue = 1'b0; op = 2'd1; src_val = 32'hFFFF_FFFF; dst_val = 32'h0; pat_a = 32'h0; pat_b = 32'h0;
        @(negedge clk);
        check(!out_valid && !res_we && !cf_we, "R10", "enables after gap",
              {29'd0, out_valid, res_we, cf_we}, 32'd0);
        check(res_data == held && cf_out == 1'b1, "R10", "held outputs", res_data, held);

        // R2 latency: issue now, output must not change before the edge
        drive(2'd2, 32'h0102_0304, 32'h0, 32'h0000_0055, 32'h0);
        #1;
        check(!out_valid && res_data == held, "R2", "no change before edge", res_data, held);
        @(negedge clk);
        issue = 1'b0;
        check(out_valid && res_data == 32'h0303_0303, "R2", "result one cycle later", res_data, 32'h0303_0303);
        @(negedge clk);
        check(!out_valid, "R2", "valid lasts one cycle", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule